// File: doc/BRIEF.md
# Decimal to BCD priority encoder

This block turns nine request lines, one for each of the decimal digits 1 to 9, into a four-bit 8-4-2-1 code. A request line is asserted by driving it low. When several lines are low together, only the one with the largest digit counts, and every lower line is ignored. The code leaves the block inverted, so a 0 on an output bit stands for a 1 in the BCD weight. There is no request line for the digit zero. Zero is what the block reports when no line is asserted, and it shows as all outputs high.

The encoding itself is pure combinational logic. A parameter chooses whether it drives the outputs directly or through one register stage. The register gives a bench a fixed sampling point. When it is present, it is cleared to the zero code (all ones) by an asynchronous active-low reset. The number of request lines is a parameter, and the code width follows from it. The default is the nine-line decimal case with the register present.

Top module: `dec_bcd_prio_enc`

## Requirements
- R1: Request line k (k = 1..9) is bit k-1 of `req_n_i` and is asserted when low. With only line k low, `bcd_n_o` equals the bitwise inverse of the 4-bit binary value k.
- R2: When several request lines are low, the output encodes the highest-numbered low line. This holds for every one of the 512 input patterns.
- R3: The output is inverted 8-4-2-1 BCD. `bcd_n_o[3]` carries weight 8, `[2]` weight 4, `[1]` weight 2 and `[0]` weight 1, and a low bit means that weight is present.
- R4: With all nine request lines high, `bcd_n_o` is 4'b1111, which is decimal zero.
- R5: With line 9 (bit 8) low, `bcd_n_o` is 4'b0110 whatever lines 1 to 8 carry.
- R6: With line 1 (bit 0) the only low line, `bcd_n_o` is 4'b1110.
- R7: With the register stage present (the default), the code for the inputs sampled at a rising clock edge appears after that edge and holds until the next one. While `rst_ni` is low, `bcd_n_o` is 4'b1111 whatever the inputs are.
- R8: While a higher line stays low, changing any lower-numbered line leaves `bcd_n_o` unchanged.
- R9: For every input pattern, the inverted output decodes to a value between 0 and 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset; the output register is cleared to the zero code |
| req_n_i | input | 9 | Active-low requests; bit k-1 is the request for digit k |
| bcd_n_o | output | 4 | Inverted 8-4-2-1 code of the highest asserted digit |

## Verification
The priority selection and the masking of lower lines always act in the same cycle. Whenever two or more lines are low, the winner is chosen and the losers are suppressed by one evaluation. The bench provokes this in two ways. It applies all 512 patterns, and it holds one high line low while it toggles every line beneath it. Each result is compared against a model that scans downward from line 9. Reset is also held low while requests are active, to show that the cleared register stage wins over a live encoding in the same cycle.

// File: rtl/dec_bcd_prio_enc_pkg.sv
package dec_bcd_prio_enc_pkg;

   // Output stage variant selected at elaboration
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_FLOP = 1'b1
   } out_stage_e;

   localparam int DEF_LINES = 9;

   // Width of a binary code able to hold 0..lines
   function automatic int code_width(input int lines);
      return (lines < 1) ? 1 : $clog2(lines + 1);
   endfunction

endpackage

// File: rtl/prio_req_norm.sv
// Converts active-low requests to active-high activity flags
module prio_req_norm #(
   parameter int LINES = 9
) (
   input  logic [LINES-1:0] req_n_i,
   output logic [LINES-1:0] act_o
);
   for (genvar i = 0; i < LINES; i++) begin : g_norm
      assign act_o[i] = ~req_n_i[i];
   end
endmodule

// File: rtl/prio_scan.sv
// Picks the highest-index active flag; output is one-hot or zero
module prio_scan #(
   parameter int LINES = 9
) (
   input  logic [LINES-1:0] act_i,
   output logic [LINES-1:0] win_o
);
   // busy[i] : some line with index >= i is active
   logic [LINES:0] busy;

   assign busy[LINES] = 1'b0;

   for (genvar i = LINES - 1; i >= 0; i--) begin : g_chain
      assign busy[i]  = busy[i+1] | act_i[i];
      assign win_o[i] = act_i[i] & ~busy[i+1];
   end
endmodule

// File: rtl/prio_code.sv
// Maps one-hot winner at index i to inverted binary value i+1
module prio_code #(
   parameter int LINES = 9,
   parameter int CW    = 4
) (
   input  logic [LINES-1:0] win_i,
   output logic [CW-1:0]    code_n_o
);
   // col[b][i] : winner i contributes to code bit b
   logic [CW-1:0][LINES-1:0] col;

   for (genvar b = 0; b < CW; b++) begin : g_bit
      for (genvar i = 0; i < LINES; i++) begin : g_line
         localparam int DIGIT = i + 1;
         if (((DIGIT >> b) & 1) == 1) begin : g_on
            assign col[b][i] = win_i[i];
         end else begin : g_off
            assign col[b][i] = 1'b0;
         end
      end
      assign code_n_o[b] = ~(|col[b]);
   end
endmodule

// File: rtl/prio_out_stage.sv
// Optional output register, cleared to all ones (zero code)
module prio_out_stage
   import dec_bcd_prio_enc_pkg::*;
#(
   parameter int         CW    = 4,
   parameter out_stage_e STAGE = OUT_FLOP
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] d_i,
   output logic [CW-1:0] q_o
);
   if (STAGE == OUT_FLOP) begin : g_flop
      logic [CW-1:0] q_r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_r <= '1;
         else         q_r <= d_i;
      end
      assign q_o = q_r;
   end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk_i ^ rst_ni;
      assign q_o       = d_i;
   end
endmodule

// File: rtl/dec_bcd_prio_enc.sv
module dec_bcd_prio_enc
   import dec_bcd_prio_enc_pkg::*;
#(
   parameter int         LINES = DEF_LINES,
   parameter out_stage_e STAGE = OUT_FLOP,
   localparam int        CW    = code_width(LINES)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LINES-1:0] req_n_i,
   output logic [CW-1:0]    bcd_n_o
);
   // Elaboration-time parameter checks
   if (LINES < 1) begin : g_bad_lines
      $error("dec_bcd_prio_enc: LINES must be at least 1");
   end
   if (CW > 16) begin : g_bad_width
      $error("dec_bcd_prio_enc: code width too large");
   end

   logic [LINES-1:0] act;
   logic [LINES-1:0] win;
   logic [CW-1:0]    code_n;

   prio_req_norm #(.LINES(LINES)) u_norm (
      .req_n_i (req_n_i),
      .act_o   (act)
   );

   prio_scan #(.LINES(LINES)) u_scan (
      .act_i (act),
      .win_o (win)
   );

   prio_code #(.LINES(LINES), .CW(CW)) u_code (
      .win_i    (win),
      .code_n_o (code_n)
   );

   prio_out_stage #(.CW(CW), .STAGE(STAGE)) u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (code_n),
      .q_o    (bcd_n_o)
   );
endmodule

// File: rtl/dec_bcd_prio_enc_chk.sv
module dec_bcd_prio_enc_chk
   import dec_bcd_prio_enc_pkg::*;
#(
   parameter int         LINES = 9,
   parameter out_stage_e STAGE = OUT_FLOP,
   parameter int         CW    = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [LINES-1:0] req_n_i,
   input logic [CW-1:0]    bcd_n_o
);
   localparam logic [CW-1:0] TOP_N  = ~CW'(LINES);
   localparam logic [CW-1:0] ONE_N  = ~CW'(1);
   localparam logic [LINES-1:0] ONLY1 = ~LINES'(1);

   // R9: decoded value never exceeds the number of lines
   assert_code_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      CW'(~bcd_n_o) <= CW'(LINES));

   if (STAGE == OUT_FLOP) begin : g_seq
      // R7: held reset forces the zero code
      assert_reset_zero_R7: assert property (@(posedge clk_i)
         !rst_ni |=> bcd_n_o == '1);
      // R4: no request gives the zero code
      assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (&req_n_i) |=> bcd_n_o == '1);
      // R5: top line dominates
      assert_top_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !req_n_i[LINES-1] |=> bcd_n_o == TOP_N);
      // R6: lone line 1
      assert_line_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (req_n_i == ONLY1) |=> bcd_n_o == ONE_N);
   end else begin : g_comb
      assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (&req_n_i) |-> bcd_n_o == '1);
      assert_top_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !req_n_i[LINES-1] |-> bcd_n_o == TOP_N);
      assert_line_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (req_n_i == ONLY1) |-> bcd_n_o == ONE_N);
   end
endmodule

bind dec_bcd_prio_enc dec_bcd_prio_enc_chk #(
   .LINES (LINES),
   .STAGE (STAGE),
   .CW    (CW)
) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .req_n_i (req_n_i),
   .bcd_n_o (bcd_n_o)
);

// File: tb/dec_bcd_prio_enc_tb_top.sv
`timescale 1ns/1ps
module dec_bcd_prio_enc_tb_top;
   localparam int HALF = 10;   // 50 MHz

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [8:0] req_n_i = '1;
   logic [3:0] bcd_n_o;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   dec_bcd_prio_enc dut_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_n_i (req_n_i),
      .bcd_n_o (bcd_n_o)
   );

   always #(HALF) clk_i = ~clk_i;

   // Reference: scan from line 9 downward
   function automatic logic [3:0] ref_code(input logic [8:0] r);
      for (int k = 9; k >= 1; k--) begin
         if (r[k-1] == 1'b0) return ~4'(k);
      end
      return 4'b1111;
   endfunction

   task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, sample at the next falling edge
   task automatic apply(input logic [8:0] v);
      @(negedge clk_i);
      req_n_i = v;
      @(negedge clk_i);
   endtask

   initial begin
      // R7: reset holds zero code despite live requests
      req_n_i = 9'h000;
      repeat (3) @(negedge clk_i);
      check(bcd_n_o, 4'b1111, "R7 reset");
      rst_ni = 1'b1;
      @(negedge clk_i);

      // R4: idle
      apply(9'h1FF);
      check(bcd_n_o, 4'b1111, "R4 idle");

      // R6: lone line 1
      apply(9'h1FE);
      check(bcd_n_o, 4'b1110, "R6 line1");

      // R1 and R3: each line alone
      for (int k = 1; k <= 9; k++) begin
         apply(~(9'(1) << (k - 1)));
         check(bcd_n_o, ~4'(k), $sformatf("R1/R3 line %0d", k));
      end

      // R5: line 9 low with all lower combinations
      for (int p = 0; p < 256; p++) begin
         apply({1'b0, 8'(p)});
         check(bcd_n_o, 4'b0110, "R5 line9");
      end

      // R8: hold line 7 low, toggle lines 1..6
      for (int p = 0; p < 64; p++) begin
         apply({2'b11, 1'b0, 6'(p)});
         check(bcd_n_o, 4'b1000, "R8 lower ignored");
      end

      // R7: latency of one register stage
      apply(9'h1FF);
      @(negedge clk_i);
      req_n_i = 9'h1EF;            // line 5
      #(HALF - 2);
      check(bcd_n_o, 4'b1111, "R7 before edge");
      @(negedge clk_i);
      check(bcd_n_o, 4'b1010, "R7 after edge");

      // R2 and R9: exhaustive
      for (int p = 0; p < 512; p++) begin
         apply(9'(p));
         check(bcd_n_o, ref_code(9'(p)), "R2 priority");
         checks++;
         if ((~bcd_n_o) > 4'd9) begin
            errors++;
            $display("FAIL R9 range: got %b expected <= 9 decoded", bcd_n_o);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(HALF * 2 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule